// File: doc/BRIEF.md
# Link Low-Power Idle Controller

This block decides when one link transmitter may drop into a low-power idle state and when it must come back. While no frame waits, it counts idle cycles. Once a programmed number of idle cycles has passed, it raises a low-power request to the link partner. After the partner acknowledges, it runs a sleep phase of fixed length and then holds the link quiet. It breaks that quiet at regular intervals for a short refresh exchange. A waiting frame starts a timed wake phase, and the transmit grant is given only once that phase has ended.

The states are ACTIVE (0), REQ (1), SLEEP (2), LPI (3), REFRESH (4) and WAKE (5). The transitions are:
- idle-timeout: ACTIVE to REQ.
- ack-accept: REQ to SLEEP.
- ack-timeout and frame-abort: REQ to ACTIVE.
- sleep-done: SLEEP to LPI.
- sleep-pending: SLEEP to WAKE.
- refresh-due: LPI to REFRESH.
- refresh-done: REFRESH to LPI.
- frame-wake: LPI or REFRESH to WAKE.
- wake-done: WAKE to ACTIVE.

The sleep and wake lengths come from a speed selector. For the three fixed speeds they are computed at elaboration from minimum durations in nanoseconds and the clock frequency. The fourth code takes both lengths from runtime inputs. All other lengths are runtime inputs counted in clock cycles. A length of 0 behaves as 1.

Top module: `lpi_ctrl`

## Requirements
- R1: While `rst` is high, and on the first cycle after it, `state_o` is 0 (ACTIVE). While `rst` is high, `tx_grant_o`, `lp_req_o` and `lpi_entry_o` are low, even if `tx_req_i` is high.
- R2: In ACTIVE, `tx_grant_o` follows `tx_req_i` in the same cycle. Every cycle with `tx_req_i` high restarts the idle count. After `cfg_idle_cyc_i` consecutive cycles with `tx_req_i` low, the state is REQ (1).
- R3: In REQ, `lp_ack_i` sampled high moves the state to SLEEP on the next cycle. If no ack arrives for `cfg_ack_cyc_i` cycles, the state returns to ACTIVE and the idle count starts again from zero. `tx_req_i` high in REQ returns to ACTIVE on the next cycle, and this takes priority over an ack in the same cycle.
- R4: SLEEP (2) lasts exactly the selected sleep length in cycles and then moves to LPI (3) if no frame is pending.
- R5: A frame request seen during SLEEP, even for a single cycle, does not shorten SLEEP. When SLEEP ends, the state moves to WAKE (5) instead of LPI.
- R6: `tx_req_i` high in LPI moves the state to WAKE on the next cycle. WAKE lasts exactly the selected wake length and then moves to ACTIVE. `tx_grant_o` is high only in ACTIVE.
- R7: After `cfg_rf_period_i` LPI cycles without a frame, the state moves to REFRESH (4). REFRESH lasts `cfg_rf_len_i` cycles and then moves back to LPI, where the refresh interval is counted from zero again.
- R8: `tx_req_i` high during REFRESH ends it. The state moves to WAKE on the next cycle, followed by the full wake length.
- R9: `lpi_entry_o` is high for exactly one cycle: the first cycle of each stay in LPI, whether that stay is entered from SLEEP or from REFRESH. A SLEEP that ends in WAKE gives no pulse.
- R10: `speed_i` sets the sleep and wake lengths. Code 0 gives 200 us and 30 us. Code 1 gives 182 us and 16 us. Code 2 gives 2.88 us and 4.48 us. Each is rounded up to whole cycles of a `CLK_MHZ` clock, so at 100 MHz they are 20000/3000, 18200/1600 and 288/448 cycles. Code 3 uses `cfg_sleep_cyc_i` and `cfg_wake_cyc_i`.
- R11: `lp_req_o` is high exactly in REQ, SLEEP and REFRESH.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| speed_i | input | 2 | Link speed code selecting the sleep and wake lengths |
| cfg_idle_cyc_i | input | CNT_W | Idle cycles before a low-power request |
| cfg_ack_cyc_i | input | CNT_W | Cycles to wait for the partner's ack |
| cfg_sleep_cyc_i | input | CNT_W | Sleep length for speed code 3 |
| cfg_wake_cyc_i | input | CNT_W | Wake length for speed code 3 |
| cfg_rf_period_i | input | CNT_W | LPI cycles between refresh exchanges |
| cfg_rf_len_i | input | CNT_W | Length of one refresh exchange |
| tx_req_i | input | 1 | A frame is waiting to be sent |
| tx_grant_o | output | 1 | Transmission is allowed |
| lp_req_o | output | 1 | Low-power request or refresh signalling toward the partner |
| lp_ack_i | input | 1 | The partner acknowledges the low-power request |
| state_o | output | 3 | Current state code |
| lpi_entry_o | output | 1 | One-cycle pulse on each entry to LPI |

## Verification
The assertions check several rules on every cycle:
- the grant appears only in ACTIVE;
- SLEEP can exit only to LPI or WAKE, so it never falls back to ACTIVE;
- REQ and WAKE can exit only along their named transitions;
- the LPI entry pulse lasts one cycle and occurs only in LPI;
- the phase counters never wrap.

The exact lengths of each phase can only be shown by the bench's scenarios, because they depend on the configuration. The same holds for the idle restart after traffic, for holding a frame request through SLEEP, for priority when a frame and an ack arrive together, and for the cycle counts each speed code produces.

// File: rtl/lpi_pkg.sv
package lpi_pkg;

    typedef enum logic [2:0] {
        ST_ACTIVE  = 3'd0,
        ST_REQ     = 3'd1,
        ST_SLEEP   = 3'd2,
        ST_LPI     = 3'd3,
        ST_REFRESH = 3'd4,
        ST_WAKE    = 3'd5
    } lpi_state_e;

    typedef enum logic [1:0] {
        SPD_100M   = 2'd0,
        SPD_1G     = 2'd1,
        SPD_10G    = 2'd2,
        SPD_CUSTOM = 2'd3
    } lpi_speed_e;

    // Minimum durations in nanoseconds for the fixed speed codes
    localparam int unsigned SLEEP_NS_100M = 200000;
    localparam int unsigned WAKE_NS_100M  = 30000;
    localparam int unsigned SLEEP_NS_1G   = 182000;
    localparam int unsigned WAKE_NS_1G    = 16000;
    localparam int unsigned SLEEP_NS_10G  = 2880;
    localparam int unsigned WAKE_NS_10G   = 4480;

    // Round up so a minimum duration is never shortened
    function automatic int unsigned ns_to_cycles(input int unsigned ns, input int unsigned mhz);
        return (ns * mhz + 999) / 1000;
    endfunction

endpackage

// File: rtl/lpi_dur_sel.sv
module lpi_dur_sel
    import lpi_pkg::*;
#(
    parameter int CNT_W   = 24,
    parameter int CLK_MHZ = 100
) (
    input  logic [1:0]       speed_i,
    input  logic [CNT_W-1:0] cfg_sleep_i,
    input  logic [CNT_W-1:0] cfg_wake_i,
    output logic [CNT_W-1:0] sleep_cyc_o,
    output logic [CNT_W-1:0] wake_cyc_o
);

    localparam logic [CNT_W-1:0] SLP_100M = CNT_W'(ns_to_cycles(SLEEP_NS_100M, CLK_MHZ));
    localparam logic [CNT_W-1:0] WK_100M  = CNT_W'(ns_to_cycles(WAKE_NS_100M,  CLK_MHZ));
    localparam logic [CNT_W-1:0] SLP_1G   = CNT_W'(ns_to_cycles(SLEEP_NS_1G,   CLK_MHZ));
    localparam logic [CNT_W-1:0] WK_1G    = CNT_W'(ns_to_cycles(WAKE_NS_1G,    CLK_MHZ));
    localparam logic [CNT_W-1:0] SLP_10G  = CNT_W'(ns_to_cycles(SLEEP_NS_10G,  CLK_MHZ));
    localparam logic [CNT_W-1:0] WK_10G   = CNT_W'(ns_to_cycles(WAKE_NS_10G,   CLK_MHZ));

    // R10: speed code selects the sleep/wake lengths
    always_comb begin
        unique case (lpi_speed_e'(speed_i))
            SPD_100M: begin sleep_cyc_o = SLP_100M; wake_cyc_o = WK_100M; end
            SPD_1G:   begin sleep_cyc_o = SLP_1G;   wake_cyc_o = WK_1G;   end
            SPD_10G:  begin sleep_cyc_o = SLP_10G;  wake_cyc_o = WK_10G;  end
            default:  begin sleep_cyc_o = cfg_sleep_i; wake_cyc_o = cfg_wake_i; end
        endcase
    end

endmodule

// File: rtl/lpi_phase_cnt.sv
module lpi_phase_cnt #(
    parameter int CNT_W = 24
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             clr_i,
    input  logic             inc_i,
    input  logic [CNT_W-1:0] limit_i,
    output logic             done_o
);

    logic [CNT_W-1:0] cnt_q;
    logic [CNT_W:0]   cnt_plus1;

    assign cnt_plus1 = {1'b0, cnt_q} + (CNT_W+1)'(1);
    // done in the cycle whose count completes the limit; 0 behaves as 1
    assign done_o    = cnt_plus1 >= {1'b0, limit_i};

    always_ff @(posedge clk) begin
        if (rst || clr_i) begin
            cnt_q <= '0;
        end else if (inc_i) begin
            cnt_q <= cnt_plus1[CNT_W-1:0];
        end
    end

    // R2/R4/R7: a counted phase ends before the counter can wrap
    assert_no_overflow_R4: assert property (@(posedge clk) disable iff (rst)
        (inc_i && !clr_i) |-> (cnt_q != '1));

endmodule

// File: rtl/lpi_fsm.sv
module lpi_fsm
    import lpi_pkg::*;
#(
    parameter int CNT_W = 24
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             tx_req_i,
    input  logic             lp_ack_i,
    input  logic [CNT_W-1:0] idle_cyc_i,
    input  logic [CNT_W-1:0] ack_cyc_i,
    input  logic [CNT_W-1:0] sleep_cyc_i,
    input  logic [CNT_W-1:0] wake_cyc_i,
    input  logic [CNT_W-1:0] rf_len_i,
    input  logic             ph_done_i,
    input  logic             rf_done_i,
    output logic [CNT_W-1:0] ph_limit_o,
    output logic             ph_clr_o,
    output logic             ph_inc_o,
    output logic             rf_clr_o,
    output logic             rf_inc_o,
    output logic             tx_grant_o,
    output logic             lp_req_o,
    output logic [2:0]       state_o,
    output logic             lpi_entry_o
);

    lpi_state_e st_q, st_d;
    logic       pend_q;
    logic       entry_q, entry_d;

    // state register
    always_ff @(posedge clk) begin
        if (rst) begin
            st_q    <= ST_ACTIVE;
            entry_q <= 1'b0;
            pend_q  <= 1'b0;
        end else begin
            st_q    <= st_d;
            entry_q <= entry_d;
            pend_q  <= (st_q == ST_SLEEP) && (st_d == ST_SLEEP) && (pend_q || tx_req_i);
        end
    end

    // next state and counter control
    always_comb begin
        st_d     = st_q;
        entry_d  = 1'b0;
        ph_clr_o = 1'b1;
        ph_inc_o = 1'b0;
        rf_clr_o = 1'b1;
        rf_inc_o = 1'b0;
        unique case (st_q)
            ST_ACTIVE: begin
                if (tx_req_i) begin
                    st_d = ST_ACTIVE;
                end else if (ph_done_i) begin
                    st_d = ST_REQ;
                end else begin
                    ph_clr_o = 1'b0;
                    ph_inc_o = 1'b1;
                end
            end
            ST_REQ: begin
                if (tx_req_i) begin
                    st_d = ST_ACTIVE;
                end else if (lp_ack_i) begin
                    st_d = ST_SLEEP;
                end else if (ph_done_i) begin
                    st_d = ST_ACTIVE;
                end else begin
                    ph_clr_o = 1'b0;
                    ph_inc_o = 1'b1;
                end
            end
            ST_SLEEP: begin
                if (ph_done_i) begin
                    if (pend_q || tx_req_i) begin
                        st_d = ST_WAKE;
                    end else begin
                        st_d    = ST_LPI;
                        entry_d = 1'b1;
                    end
                end else begin
                    ph_clr_o = 1'b0;
                    ph_inc_o = 1'b1;
                end
            end
            ST_LPI: begin
                if (tx_req_i) begin
                    st_d = ST_WAKE;
                end else if (rf_done_i) begin
                    st_d = ST_REFRESH;
                end else begin
                    rf_clr_o = 1'b0;
                    rf_inc_o = 1'b1;
                end
            end
            ST_REFRESH: begin
                if (tx_req_i) begin
                    st_d = ST_WAKE;
                end else if (ph_done_i) begin
                    st_d    = ST_LPI;
                    entry_d = 1'b1;
                end else begin
                    ph_clr_o = 1'b0;
                    ph_inc_o = 1'b1;
                end
            end
            ST_WAKE: begin
                if (ph_done_i) begin
                    st_d = ST_ACTIVE;
                end else begin
                    ph_clr_o = 1'b0;
                    ph_inc_o = 1'b1;
                end
            end
            default: st_d = ST_ACTIVE;
        endcase
    end

    // outputs
    always_comb begin
        unique case (st_q)
            ST_ACTIVE:  ph_limit_o = idle_cyc_i;
            ST_REQ:     ph_limit_o = ack_cyc_i;
            ST_SLEEP:   ph_limit_o = sleep_cyc_i;
            ST_REFRESH: ph_limit_o = rf_len_i;
            ST_WAKE:    ph_limit_o = wake_cyc_i;
            default:    ph_limit_o = '0;
        endcase
        tx_grant_o  = !rst && (st_q == ST_ACTIVE) && tx_req_i;
        lp_req_o    = (st_q == ST_REQ) || (st_q == ST_SLEEP) || (st_q == ST_REFRESH);
        state_o     = st_q;
        lpi_entry_o = entry_q;
    end

    assert_reset_state_R1: assert property (@(posedge clk)
        rst |=> (st_q == ST_ACTIVE) && !entry_q);

    assert_req_exit_R3: assert property (@(posedge clk) disable iff (rst)
        (st_q == ST_REQ) |=> (st_q inside {ST_REQ, ST_SLEEP, ST_ACTIVE}));

    assert_sleep_no_abort_R5: assert property (@(posedge clk) disable iff (rst)
        (st_q == ST_SLEEP) |=> (st_q inside {ST_SLEEP, ST_LPI, ST_WAKE}));

    assert_grant_active_R6: assert property (@(posedge clk) disable iff (rst)
        tx_grant_o |-> (st_q == ST_ACTIVE));

    assert_wake_exit_R6: assert property (@(posedge clk) disable iff (rst)
        (st_q == ST_WAKE) |=> (st_q inside {ST_WAKE, ST_ACTIVE}));

    assert_entry_in_lpi_R9: assert property (@(posedge clk) disable iff (rst)
        lpi_entry_o |-> (st_q == ST_LPI));

    assert_entry_single_R9: assert property (@(posedge clk) disable iff (rst)
        lpi_entry_o |=> !lpi_entry_o);

endmodule

// File: rtl/lpi_ctrl.sv
module lpi_ctrl
    import lpi_pkg::*;
#(
    parameter int CNT_W   = 24,
    parameter int CLK_MHZ = 100
) (
    input  logic             clk,
    input  logic             rst,
    input  logic [1:0]       speed_i,
    input  logic [CNT_W-1:0] cfg_idle_cyc_i,
    input  logic [CNT_W-1:0] cfg_ack_cyc_i,
    input  logic [CNT_W-1:0] cfg_sleep_cyc_i,
    input  logic [CNT_W-1:0] cfg_wake_cyc_i,
    input  logic [CNT_W-1:0] cfg_rf_period_i,
    input  logic [CNT_W-1:0] cfg_rf_len_i,
    input  logic             tx_req_i,
    output logic             tx_grant_o,
    output logic             lp_req_o,
    input  logic             lp_ack_i,
    output logic [2:0]       state_o,
    output logic             lpi_entry_o
);

    logic [CNT_W-1:0] sleep_cyc, wake_cyc, ph_limit;
    logic             ph_clr, ph_inc, ph_done;
    logic             rf_clr, rf_inc, rf_done;

    lpi_dur_sel #(.CNT_W(CNT_W), .CLK_MHZ(CLK_MHZ)) u_dur (
        .speed_i     (speed_i),
        .cfg_sleep_i (cfg_sleep_cyc_i),
        .cfg_wake_i  (cfg_wake_cyc_i),
        .sleep_cyc_o (sleep_cyc),
        .wake_cyc_o  (wake_cyc)
    );

    // shared phase counter: idle, ack wait, sleep, refresh, wake
    lpi_phase_cnt #(.CNT_W(CNT_W)) u_phase (
        .clk     (clk),
        .rst     (rst),
        .clr_i   (ph_clr),
        .inc_i   (ph_inc),
        .limit_i (ph_limit),
        .done_o  (ph_done)
    );

    // refresh interval timer, counts only in LPI
    lpi_phase_cnt #(.CNT_W(CNT_W)) u_refresh (
        .clk     (clk),
        .rst     (rst),
        .clr_i   (rf_clr),
        .inc_i   (rf_inc),
        .limit_i (cfg_rf_period_i),
        .done_o  (rf_done)
    );

    lpi_fsm #(.CNT_W(CNT_W)) u_fsm (
        .clk         (clk),
        .rst         (rst),
        .tx_req_i    (tx_req_i),
        .lp_ack_i    (lp_ack_i),
        .idle_cyc_i  (cfg_idle_cyc_i),
        .ack_cyc_i   (cfg_ack_cyc_i),
        .sleep_cyc_i (sleep_cyc),
        .wake_cyc_i  (wake_cyc),
        .rf_len_i    (cfg_rf_len_i),
        .ph_done_i   (ph_done),
        .rf_done_i   (rf_done),
        .ph_limit_o  (ph_limit),
        .ph_clr_o    (ph_clr),
        .ph_inc_o    (ph_inc),
        .rf_clr_o    (rf_clr),
        .rf_inc_o    (rf_inc),
        .tx_grant_o  (tx_grant_o),
        .lp_req_o    (lp_req_o),
        .state_o     (state_o),
        .lpi_entry_o (lpi_entry_o)
    );

endmodule

// File: tb/lpi_ctrl_tb_top.sv
module lpi_ctrl_tb_top;

    localparam int CW = 24;
    localparam int S_ACT = 0, S_REQ = 1, S_SLP = 2, S_LPI = 3, S_RFR = 4, S_WAKE = 5;

    typedef struct packed {
        logic [1:0] spd;
        int         idle;
        int         ack_at;
        int         slp;
        int         wk;
        int         exp_slp;
        int         exp_wk;
    } vec_t;

    localparam int NV = 6;
    localparam vec_t VECS [NV] = '{
        '{2'd3, 5,  1, 4,  3, 4,     3},
        '{2'd3, 1,  3, 1,  1, 1,     1},
        '{2'd3, 20, 8, 10, 7, 10,    7},
        '{2'd2, 3,  1, 0,  0, 288,   448},
        '{2'd1, 2,  2, 0,  0, 18200, 1600},
        '{2'd0, 2,  1, 0,  0, 20000, 3000}
    };

    logic          clk = 1'b0;
    logic          rst = 1'b1;
    logic [1:0]    speed = 2'd3;
    logic [CW-1:0] c_idle = CW'(4), c_ack = CW'(8), c_slp = CW'(2), c_wk = CW'(2);
    logic [CW-1:0] c_rfp = CW'(1000000), c_rfl = CW'(2);
    logic          tx_req = 1'b0, lp_ack = 1'b0;
    logic          tx_grant, lp_req, lpi_entry;
    logic [2:0]    state;

    int errs = 0, checks = 0, cyc = 0;
    bit finished = 1'b0;

    always #5 clk = ~clk;
    always @(posedge clk) cyc <= cyc + 1;

    lpi_ctrl #(.CNT_W(CW), .CLK_MHZ(100)) dut_i (
        .clk             (clk),
        .rst             (rst),
        .speed_i         (speed),
        .cfg_idle_cyc_i  (c_idle),
        .cfg_ack_cyc_i   (c_ack),
        .cfg_sleep_cyc_i (c_slp),
        .cfg_wake_cyc_i  (c_wk),
        .cfg_rf_period_i (c_rfp),
        .cfg_rf_len_i    (c_rfl),
        .tx_req_i        (tx_req),
        .tx_grant_o      (tx_grant),
        .lp_req_o        (lp_req),
        .lp_ack_i        (lp_ack),
        .state_o         (state),
        .lpi_entry_o     (lpi_entry)
    );

    task automatic chk(input string rq, input string what, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errs++;
            $display("FAIL %s %s: actual=%0d expected=%0d", rq, what, act, exp);
        end
    endtask

    task automatic step();
        @(negedge clk);
    endtask

    task automatic count_while(input int s, output int n);
        n = 0;
        while (int'(state) == s && n < 100000) begin
            @(negedge clk);
            n++;
        end
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst = 1'b1; tx_req = 1'b0; lp_ack = 1'b0;
        repeat (2) @(negedge clk);
        rst = 1'b0;
    endtask

    // from reset release: idle out, ack on first REQ cycle, end in first SLEEP cycle
    task automatic enter_sleep();
        int n;
        count_while(S_ACT, n);
        lp_ack = 1'b1;
        step();
        lp_ack = 1'b0;
    endtask

    initial begin : watchdog
        forever begin
            @(posedge clk);
            if (cyc > 190000 && !finished) begin
                finished = 1'b1;
                errs++; checks++;
                $display("FAIL watchdog: actual=%0d expected=%0d cycles", cyc, 190000);
                $display("Result: errors=%0d of %0d checks", errs, checks);
                $finish;
            end
        end
    end

    initial begin : main
        int n;

        // R1: reset state with a frame request present
        tx_req = 1'b1;
        repeat (3) step();
        #1;
        chk("R1", "state in reset", int'(state), S_ACT);
        chk("R1", "grant in reset", int'(tx_grant), 0);
        chk("R1", "lp_req in reset", int'(lp_req), 0);
        chk("R1", "entry in reset", int'(lpi_entry), 0);
        tx_req = 1'b0;

        // vector table: full cycle idle -> REQ -> SLEEP -> LPI -> WAKE -> ACTIVE
        for (int i = 0; i < NV; i++) begin
            speed  = VECS[i].spd;
            c_idle = CW'(VECS[i].idle);
            c_slp  = CW'(VECS[i].slp);
            c_wk   = CW'(VECS[i].wk);
            c_ack  = CW'(8);
            c_rfp  = CW'(1000000);
            do_reset();
            count_while(S_ACT, n);
            chk("R2", "idle cycles to REQ", n, VECS[i].idle);
            chk("R11", "lp_req in REQ", int'(lp_req), 1);
            repeat (VECS[i].ack_at - 1) step();
            chk("R3", "still REQ before ack", int'(state), S_REQ);
            lp_ack = 1'b1;
            step();
            lp_ack = 1'b0;
            chk("R3", "ack enters SLEEP", int'(state), S_SLP);
            count_while(S_SLP, n);
            chk("R10", "sleep length", n, VECS[i].exp_slp);
            chk("R4", "sleep ends in LPI", int'(state), S_LPI);
            chk("R9", "entry pulse high", int'(lpi_entry), 1);
            chk("R11", "lp_req low in LPI", int'(lp_req), 0);
            step();
            chk("R9", "entry pulse one cycle", int'(lpi_entry), 0);
            tx_req = 1'b1;
            step();
            chk("R6", "frame wakes", int'(state), S_WAKE);
            #1;
            chk("R6", "no grant in WAKE", int'(tx_grant), 0);
            count_while(S_WAKE, n);
            chk("R10", "wake length", n, VECS[i].exp_wk);
            #1;
            chk("R6", "ACTIVE after wake", int'(state), S_ACT);
            chk("R6", "grant after wake", int'(tx_grant), 1);
            tx_req = 1'b0;
        end

        speed = 2'd3; c_ack = CW'(4); c_slp = CW'(6); c_wk = CW'(3);

        // R2: traffic restarts the idle count
        c_idle = CW'(6);
        do_reset();
        repeat (4) step();
        chk("R2", "ACTIVE before timeout", int'(state), S_ACT);
        tx_req = 1'b1;
        #1;
        chk("R2", "grant follows request", int'(tx_grant), 1);
        step();
        tx_req = 1'b0;
        count_while(S_ACT, n);
        chk("R2", "idle restarted", n, 6);

        // R3: ack timeout and restart of idle count
        c_idle = CW'(2);
        do_reset();
        count_while(S_ACT, n);
        count_while(S_REQ, n);
        chk("R3", "ack wait length", n, 4);
        chk("R3", "timeout to ACTIVE", int'(state), S_ACT);
        count_while(S_ACT, n);
        chk("R3", "idle count restarted", n, 2);

        // R3: frame in REQ wins over a simultaneous ack
        do_reset();
        count_while(S_ACT, n);
        tx_req = 1'b1; lp_ack = 1'b1;
        step();
        lp_ack = 1'b0;
        #1;
        chk("R3", "frame aborts REQ", int'(state), S_ACT);
        chk("R3", "grant after abort", int'(tx_grant), 1);
        tx_req = 1'b0;

        // R5: one-cycle frame pulse during SLEEP is held
        do_reset();
        enter_sleep();
        step(); step();
        tx_req = 1'b1;
        step();
        tx_req = 1'b0;
        chk("R5", "sleep not aborted", int'(state), S_SLP);
        count_while(S_SLP, n);
        chk("R5", "remaining sleep", n, 3);
        chk("R5", "sleep ends in WAKE", int'(state), S_WAKE);
        chk("R9", "no entry pulse", int'(lpi_entry), 0);
        count_while(S_WAKE, n);
        chk("R5", "full wake after sleep", n, 3);
        chk("R5", "ACTIVE after wake", int'(state), S_ACT);

        // R7: periodic refresh
        c_slp = CW'(2); c_rfp = CW'(5); c_rfl = CW'(2); c_wk = CW'(4);
        do_reset();
        enter_sleep();
        count_while(S_SLP, n);
        count_while(S_LPI, n);
        chk("R7", "refresh interval", n, 5);
        chk("R7", "in REFRESH", int'(state), S_RFR);
        chk("R11", "lp_req in REFRESH", int'(lp_req), 1);
        count_while(S_RFR, n);
        chk("R7", "refresh length", n, 2);
        chk("R9", "entry after refresh", int'(lpi_entry), 1);
        count_while(S_LPI, n);
        chk("R7", "interval restarts", n, 5);

        // R8: frame during refresh goes straight to WAKE
        c_rfl = CW'(10);
        step();
        chk("R8", "in long REFRESH", int'(state), S_RFR);
        tx_req = 1'b1;
        step();
        chk("R8", "refresh ends in WAKE", int'(state), S_WAKE);
        count_while(S_WAKE, n);
        chk("R8", "wake length", n, 4);
        #1;
        chk("R8", "grant after wake", int'(tx_grant), 1);
        tx_req = 1'b0;

        // R1: reset from deep in LPI
        c_rfp = CW'(1000);
        do_reset();
        enter_sleep();
        count_while(S_SLP, n);
        step();
        rst = 1'b1;
        step();
        chk("R1", "reset leaves LPI", int'(state), S_ACT);
        chk("R1", "lp_req cleared", int'(lp_req), 0);
        rst = 1'b0;

        finished = 1'b1;
        $display("Result: errors=%0d of %0d checks", errs, checks);
        $finish;
    end

endmodule